// File: doc/BRIEF.md
# FPU Environment Image Sequencer

This block moves the floating-point unit's environment between a set of parallel state fields and a compact memory image. The environment is the control word, the status word, the tag word, the instruction pointer offset and selector, the 11-bit last opcode, and the operand pointer offset and selector. A store serializes these fields into seven consecutive slots. A load reads the seven slots back, unpacks them and presents the restored fields on the register-side outputs.

Four image layouts exist. Two mode bits, latched at start, select one: protected-mode enable and 32-bit operand size. The narrow layouts use 16-bit slots and the wide layouts use 32-bit slots. In the real-mode layouts each pointer is stored as a linear address, formed as selector times 16 plus offset, and split across two slots. The opcode shares a slot with the upper instruction-pointer bits. The memory side issues one request at a time and waits for a done pulse on each. At the end the block reports the address just past the image.

Top module: `fenv_image_seq`

## Requirements
- R1: After reset, busy, done and memReq are 0, and all restored-field outputs are 0.
- R2: One operation makes exactly 7 transfers, each held on memReq until memDone. The address of slot k is base + 2k for narrow layouts (memWide=0) and base + 4k for wide layouts (memWide=1). memWrite is 1 for a store and 0 for a load.
- R3: A store writes slots 0, 1 and 2 as the control word, the status word and the tag word. In the status word, bits 13:11 are replaced by topIn. In wide layouts the upper 16 bits of these three slots are all ones.
- R4: Narrow real-mode store (protMode=0, op32=0), with linear L = sel*16 + off. Slot 3 = IP L[15:0]. Slot 4 = {IP L[19:16], 0, opcode}. Slot 5 = operand L[15:0]. Slot 6 = {operand L[19:16], 12'b0}.
- R5: Wide real-mode store (protMode=0, op32=1). Slots 3 and 5 = {16'hFFFF, L[15:0]}. Slot 4 = {4'b0, IP L[31:16], 0, opcode}. Slot 6 = {4'b0, operand L[31:16], 12'b0}.
- R6: Protected store. Narrow: slot 3 = IP offset[15:0], slot 4 = IP selector, slot 5 = operand offset[15:0], slot 6 = operand selector. Wide: slot 3 = IP offset, slot 4 = {5'b0, opcode, IP selector}, slot 5 = operand offset, slot 6 = {16'hFFFF, operand selector}.
- R7: Real-mode load sets both selectors to 0 and the opcode to slot 4 bits 10:0. Each offset becomes the full linear pointer: narrow {12'b0, hi[15:12], lo[15:0]}, wide {hi[27:12], lo[15:0]}. Here lo is slot 3 or 5 and hi is slot 4 or 6.
- R8: Protected load. Narrow: offsets = slot 3 and slot 5 bits 15:0, selectors = slot 4 and slot 6 bits 15:0, opcode keeps the value of opcIn latched at start. Wide: offsets = slot 3 and slot 5, selectors = slot 4 and slot 6 bits 15:0, opcode = slot 4 bits 26:16.
- R9: After a load, the control output is slot 0 with bits 15:13 and 7 cleared and bit 6 set. topOut equals bits 13:11 of the loaded status word, and the tag output is slot 2 bits 15:0.
- R10: After a load, if any status bit 5:0 is 1 while the same control bit is 0, status bits 15 and 7 are set. Otherwise both are cleared.
- R11: done is a one-cycle pulse, 2 cycles after the clock edge that accepts the last memDone, with busy 0. endAddr is base + 14 for narrow layouts and base + 28 for wide layouts.
- R12: A start while busy is ignored. The running operation keeps its mode and base, and no extra transfers follow.
- R13: A store leaves all restored-field outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse (accepted only when idle) |
| dirLoad | input | 1 | 1 = load image from memory, 0 = store |
| protMode | input | 1 | Protected-mode layout select |
| op32 | input | 1 | Wide (32-bit slot) layout select |
| baseAddr | input | AW | Image base address |
| ctlIn | input | 16 | Control word to store |
| statIn | input | 16 | Status word to store |
| tagIn | input | 16 | Tag word to store |
| topIn | input | 3 | Stack-top pointer merged into status on store |
| ipOffIn | input | 32 | Instruction pointer offset |
| ipSelIn | input | 16 | Instruction pointer selector |
| opcIn | input | 11 | Last opcode |
| dpOffIn | input | 32 | Operand pointer offset |
| dpSelIn | input | 16 | Operand pointer selector |
| memReq | output | 1 | Memory request, held until memDone |
| memWrite | output | 1 | 1 = write request |
| memWide | output | 1 | 1 = 32-bit access, 0 = 16-bit |
| memAddr | output | AW | Access address |
| memWdata | output | 32 | Write data (upper half 0 when narrow) |
| memRdata | input | 32 | Read data |
| memDone | input | 1 | Access complete |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| endAddr | output | AW | Address just past the image |
| ctlOut | output | 16 | Restored control word |
| statOut | output | 16 | Restored status word |
| tagOut | output | 16 | Restored tag word |
| topOut | output | 3 | Restored stack-top pointer |
| ipOffOut | output | 32 | Restored instruction pointer offset |
| ipSelOut | output | 16 | Restored instruction pointer selector |
| opcOut | output | 11 | Restored opcode |
| dpOffOut | output | 32 | Restored operand pointer offset |
| dpSelOut | output | 16 | Restored operand pointer selector |

## Verification
The memory model answers each request a chosen number of cycles after the request appears. Each transfer takes effect on the clock edge where memDone is high. The bench checks the address and count of every transfer at that point. The restored fields and done change together, 2 cycles after the edge that accepts the final memDone: one cycle to capture the last slot and one to commit. The bench logs the cycle number of each accepted transfer and compares it with the cycle in which done is seen, sampling every output on the falling clock edge. Memory contents and restored fields are checked only after done. A busy restart is checked over the following idle cycles.

// File: rtl/fenv_pkg.sv
package fenv_pkg;

  localparam int SLOTS  = 7;
  localparam int SLOT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              latch;    // take mode, base and fields at start
    logic              capture;  // store read data into current slot
    logic              commit;   // publish unpacked fields
    logic [SLOT_W-1:0] slot;     // current slot index
  } envStrobe_t;

  // control-word bits that survive a load; bit 6 is forced high
  localparam logic [15:0] CTL_KEEP  = 16'h1F3F;
  localparam logic [15:0] CTL_FORCE = 16'h0040;
  localparam int          EXC_BITS  = 6;
  localparam int          SUM_BIT   = 7;
  localparam int          BUSY_BIT  = 15;
  localparam int          TOP_LO    = 11;

endpackage

// File: rtl/fenv_ctrl.sv
module fenv_ctrl
  import fenv_pkg::*;
#(
  parameter int NSLOT = SLOTS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dirLoadIn,
  input  logic       memDone,
  output envStrobe_t strobe,
  output logic       memReq,
  output logic       memWrite,
  output logic       busy,
  output logic       done
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);

  seqState_t         state;
  logic [SLOT_W-1:0] slotIdx;
  logic              loadMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slotIdx  <= '0;
      loadMode <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_XFER;
            slotIdx  <= '0;
            loadMode <= dirLoadIn;
          end
        end
        ST_XFER: begin
          if (memDone) begin
            if (slotIdx == LAST_SLOT) state <= ST_FIN;
            else slotIdx <= slotIdx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latch   = (state == ST_IDLE) && start;
    strobe.capture = (state == ST_XFER) && memDone && loadMode;
    strobe.commit  = (state == ST_FIN) && loadMode;
    strobe.slot    = slotIdx;
  end

  assign memReq   = (state == ST_XFER);
  assign memWrite = memReq && !loadMode;
  assign busy     = (state != ST_IDLE);

  // R2: a request stays up on the same slot until memory answers
  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq && $stable(slotIdx));

  // R11: done lasts a single cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: done only follows the finishing state
  a_r11_done_after_fin: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(state == ST_FIN));

  // R12: a start during an operation leaves the direction alone
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(loadMode));

endmodule

// File: rtl/fenv_dp.sv
module fenv_dp
  import fenv_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSLOT = SLOTS
) (
  input  logic          clk,
  input  logic          rstN,
  input  envStrobe_t    strobe,
  input  logic          protMode,
  input  logic          op32,
  input  logic [AW-1:0] baseAddr,
  input  logic [15:0]   ctlIn,
  input  logic [15:0]   statIn,
  input  logic [15:0]   tagIn,
  input  logic [2:0]    topIn,
  input  logic [31:0]   ipOffIn,
  input  logic [15:0]   ipSelIn,
  input  logic [10:0]   opcIn,
  input  logic [31:0]   dpOffIn,
  input  logic [15:0]   dpSelIn,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWide,
  output logic [31:0]   memWdata,
  output logic [AW-1:0] endAddr,
  output logic [15:0]   ctlOut,
  output logic [15:0]   statOut,
  output logic [15:0]   tagOut,
  output logic [2:0]    topOut,
  output logic [31:0]   ipOffOut,
  output logic [15:0]   ipSelOut,
  output logic [10:0]   opcOut,
  output logic [31:0]   dpOffOut,
  output logic [15:0]   dpSelOut
);

  localparam int NARROW_BYTES = NSLOT * 2;
  localparam int WIDE_BYTES   = NSLOT * 4;
  localparam int IMG_N        = 2 ** SLOT_W;

  // latched request
  logic          modeProt, modeWide;
  logic [AW-1:0] baseQ;
  logic [15:0]   ctlQ, statQ, tagQ, ipSelQ, dpSelQ;
  logic [2:0]    topQ;
  logic [31:0]   ipOffQ, dpOffQ;
  logic [10:0]   opcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeProt <= 1'b0;
      modeWide <= 1'b0;
      baseQ    <= '0;
      endAddr  <= '0;
      ctlQ     <= '0;
      statQ    <= '0;
      tagQ     <= '0;
      topQ     <= '0;
      ipOffQ   <= '0;
      ipSelQ   <= '0;
      opcQ     <= '0;
      dpOffQ   <= '0;
      dpSelQ   <= '0;
    end else if (strobe.latch) begin
      modeProt <= protMode;
      modeWide <= op32;
      baseQ    <= baseAddr;
      endAddr  <= baseAddr + (op32 ? AW'(WIDE_BYTES) : AW'(NARROW_BYTES));
      ctlQ     <= ctlIn;
      statQ    <= statIn;
      tagQ     <= tagIn;
      topQ     <= topIn;
      ipOffQ   <= ipOffIn;
      ipSelQ   <= ipSelIn;
      opcQ     <= opcIn;
      dpOffQ   <= dpOffIn;
      dpSelQ   <= dpSelIn;
    end
  end

  // ---------------- address sequencing ----------------
  assign memWide = modeWide;
  assign memAddr = baseQ + (modeWide ? (AW'(strobe.slot) << 2) : (AW'(strobe.slot) << 1));

  // ---------------- store packing ----------------
  logic [15:0] statFresh, hiFill;
  logic [31:0] ipLin, dpLin;
  logic [31:0] image [IMG_N];

  assign statFresh = {statQ[15:14], topQ, statQ[10:0]};
  assign hiFill    = modeWide ? 16'hFFFF : 16'h0000;
  assign ipLin     = {12'b0, ipSelQ, 4'b0} + ipOffQ;
  assign dpLin     = {12'b0, dpSelQ, 4'b0} + dpOffQ;

  always_comb begin
    for (int i = 0; i < IMG_N; i++) image[i] = 32'b0;
    image[0] = {hiFill, ctlQ};
    image[1] = {hiFill, statFresh};
    image[2] = {hiFill, tagQ};
    case ({modeWide, modeProt})
      2'b00: begin
        image[3] = {16'b0, ipLin[15:0]};
        image[4] = {16'b0, ipLin[19:16], 1'b0, opcQ};
        image[5] = {16'b0, dpLin[15:0]};
        image[6] = {16'b0, dpLin[19:16], 12'b0};
      end
      2'b01: begin
        image[3] = {16'b0, ipOffQ[15:0]};
        image[4] = {16'b0, ipSelQ};
        image[5] = {16'b0, dpOffQ[15:0]};
        image[6] = {16'b0, dpSelQ};
      end
      2'b10: begin
        image[3] = {16'hFFFF, ipLin[15:0]};
        image[4] = {4'b0, ipLin[31:16], 1'b0, opcQ};
        image[5] = {16'hFFFF, dpLin[15:0]};
        image[6] = {4'b0, dpLin[31:16], 12'b0};
      end
      default: begin
        image[3] = ipOffQ;
        image[4] = {5'b0, opcQ, ipSelQ};
        image[5] = dpOffQ;
        image[6] = {16'hFFFF, dpSelQ};
      end
    endcase
  end

  assign memWdata = image[strobe.slot];

  // ---------------- load capture ----------------
  logic [31:0] rawW [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : gCap
    logic [31:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) slotQ <= '0;
      else if (strobe.capture && (strobe.slot == SLOT_W'(g))) slotQ <= memRdata;
    end
    assign rawW[g] = slotQ;
  end

  // ---------------- load unpacking ----------------
  logic [15:0] ctlNew, statNew;
  logic        pendExc;
  logic [31:0] ipOffNew, dpOffNew;
  logic [15:0] ipSelNew, dpSelNew;
  logic [10:0] opcNew;

  always_comb begin
    ctlNew  = (rawW[0][15:0] & CTL_KEEP) | CTL_FORCE;
    pendExc = |(rawW[1][EXC_BITS-1:0] & ~ctlNew[EXC_BITS-1:0]);
    statNew = rawW[1][15:0];
    statNew[SUM_BIT]  = pendExc;
    statNew[BUSY_BIT] = pendExc;
    case ({modeWide, modeProt})
      2'b00: begin
        ipOffNew = {12'b0, rawW[4][15:12], rawW[3][15:0]};
        dpOffNew = {12'b0, rawW[6][15:12], rawW[5][15:0]};
        ipSelNew = '0;
        dpSelNew = '0;
        opcNew   = rawW[4][10:0];
      end
      2'b01: begin
        ipOffNew = {16'b0, rawW[3][15:0]};
        dpOffNew = {16'b0, rawW[5][15:0]};
        ipSelNew = rawW[4][15:0];
        dpSelNew = rawW[6][15:0];
        opcNew   = opcQ;
      end
      2'b10: begin
        ipOffNew = {rawW[4][27:12], rawW[3][15:0]};
        dpOffNew = {rawW[6][27:12], rawW[5][15:0]};
        ipSelNew = '0;
        dpSelNew = '0;
        opcNew   = rawW[4][10:0];
      end
      default: begin
        ipOffNew = rawW[3];
        dpOffNew = rawW[5];
        ipSelNew = rawW[4][15:0];
        dpSelNew = rawW[6][15:0];
        opcNew   = rawW[4][26:16];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlOut   <= '0;
      statOut  <= '0;
      tagOut   <= '0;
      topOut   <= '0;
      ipOffOut <= '0;
      ipSelOut <= '0;
      opcOut   <= '0;
      dpOffOut <= '0;
      dpSelOut <= '0;
    end else if (strobe.commit) begin
      ctlOut   <= ctlNew;
      statOut  <= statNew;
      tagOut   <= rawW[2][15:0];
      topOut   <= rawW[1][TOP_LO+2:TOP_LO];
      ipOffOut <= ipOffNew;
      ipSelOut <= ipSelNew;
      opcOut   <= opcNew;
      dpOffOut <= dpOffNew;
      dpSelOut <= dpSelNew;
    end
  end

  // R9: committed control word has its fixed bits in place
  a_r9_ctl_fixed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> ctlOut[6] && !ctlOut[7] && (ctlOut[15:13] == 3'b000));

  // R9: stack-top output agrees with the status it was taken from
  a_r9_top_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> topOut == statOut[TOP_LO+2:TOP_LO]);

  // R10: summary and busy flags always move together after a load
  a_r10_flags_pair: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> statOut[SUM_BIT] == statOut[BUSY_BIT]);

  // R2: every address lies inside the image
  a_r2_addr_in_image: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr - baseQ) < (modeWide ? AW'(WIDE_BYTES) : AW'(NARROW_BYTES)));

endmodule

// File: rtl/fenv_image_seq.sv
module fenv_image_seq
  import fenv_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          dirLoad,
  input  logic          protMode,
  input  logic          op32,
  input  logic [AW-1:0] baseAddr,
  input  logic [15:0]   ctlIn,
  input  logic [15:0]   statIn,
  input  logic [15:0]   tagIn,
  input  logic [2:0]    topIn,
  input  logic [31:0]   ipOffIn,
  input  logic [15:0]   ipSelIn,
  input  logic [10:0]   opcIn,
  input  logic [31:0]   dpOffIn,
  input  logic [15:0]   dpSelIn,
  output logic          memReq,
  output logic          memWrite,
  output logic          memWide,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memDone,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] endAddr,
  output logic [15:0]   ctlOut,
  output logic [15:0]   statOut,
  output logic [15:0]   tagOut,
  output logic [2:0]    topOut,
  output logic [31:0]   ipOffOut,
  output logic [15:0]   ipSelOut,
  output logic [10:0]   opcOut,
  output logic [31:0]   dpOffOut,
  output logic [15:0]   dpSelOut
);

  envStrobe_t strobe;

  fenv_ctrl #(.NSLOT(SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .dirLoadIn(dirLoad),
    .memDone(memDone), .strobe(strobe), .memReq(memReq),
    .memWrite(memWrite), .busy(busy), .done(done)
  );

  fenv_dp #(.AW(AW), .NSLOT(SLOTS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .protMode(protMode), .op32(op32), .baseAddr(baseAddr),
    .ctlIn(ctlIn), .statIn(statIn), .tagIn(tagIn), .topIn(topIn),
    .ipOffIn(ipOffIn), .ipSelIn(ipSelIn), .opcIn(opcIn),
    .dpOffIn(dpOffIn), .dpSelIn(dpSelIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWide(memWide), .memWdata(memWdata),
    .endAddr(endAddr), .ctlOut(ctlOut), .statOut(statOut),
    .tagOut(tagOut), .topOut(topOut), .ipOffOut(ipOffOut),
    .ipSelOut(ipSelOut), .opcOut(opcOut), .dpOffOut(dpOffOut),
    .dpSelOut(dpSelOut)
  );

endmodule

// File: tb/fenv_image_seq_test.sv
`timescale 1ns/1ps
module fenv_image_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, dirLoad = 1'b0, protMode = 1'b0, op32 = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [15:0] ctlIn = '0, statIn = '0, tagIn = '0, ipSelIn = '0, dpSelIn = '0;
  logic [2:0]  topIn = '0;
  logic [31:0] ipOffIn = '0, dpOffIn = '0;
  logic [10:0] opcIn = '0;
  logic        memReq, memWrite, memWide, busy, done;
  logic [31:0] memAddr, memWdata, endAddr;
  logic [31:0] memRdata = '0;
  logic        memDone = 1'b0;
  logic [15:0] ctlOut, statOut, tagOut, ipSelOut, dpSelOut;
  logic [2:0]  topOut;
  logic [31:0] ipOffOut, dpOffOut;
  logic [10:0] opcOut;

  always #5 clk = ~clk;

  fenv_image_seq #(.AW(32)) uut (.*);

  int checks = 0, fails = 0;
  logic [7:0] mem [0:255];
  int lat = 1, waitCnt = 0, xferCount = 0, xferBad = 0;
  logic [31:0] expBase = 0;
  int expStride = 2;
  int cyc = 0, lastXfer = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: answers after lat idle cycles, one access per request
  always @(negedge clk) begin
    if (memDone) begin
      memDone = 1'b0;
      waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        automatic logic [7:0] a = memAddr[7:0];
        if (memAddr != expBase + 32'(xferCount * expStride)) xferBad++;
        if (memWrite) begin
          mem[a] = memWdata[7:0]; mem[a+8'd1] = memWdata[15:8];
          if (memWide) begin mem[a+8'd2] = memWdata[23:16]; mem[a+8'd3] = memWdata[31:24]; end
        end
        memRdata = {mem[a+8'd3], mem[a+8'd2], mem[a+8'd1], mem[a]};
        xferCount++;
        memDone = 1'b1;
      end else waitCnt++;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq && memDone) lastXfer <= cyc;
  end

  function automatic logic [31:0] rdMem(logic [7:0] a, bit w);
    return w ? {mem[a+8'd3], mem[a+8'd2], mem[a+8'd1], mem[a]} : {16'h0, mem[a+8'd1], mem[a]};
  endfunction

  task automatic fillMem(logic [7:0] v);
    for (int i = 0; i < 256; i++) mem[i] = v;
  endtask

  task automatic putWord(logic [7:0] a, logic [31:0] v, bit w);
    mem[a] = v[7:0]; mem[a+8'd1] = v[15:8];
    if (w) begin mem[a+8'd2] = v[23:16]; mem[a+8'd3] = v[31:24]; end
  endtask

  task automatic launch(bit ld, bit p, bit w, logic [31:0] b);
    @(negedge clk);
    dirLoad = ld; protMode = p; op32 = w; baseAddr = b;
    expBase = b; expStride = w ? 4 : 2; xferCount = 0; xferBad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R2, R11: wait for done and check timing, count, order, end address
  task automatic waitDone(bit ld, bit w, logic [31:0] b);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); if (!done) n++; end
    chk(done, "R11", "done seen", 32'(done), 1);
    chk(cyc - lastXfer == 2, "R11", "done delay after last transfer", 32'(cyc - lastXfer), 2);
    chk(!busy, "R11", "busy low at done", 32'(busy), 0);
    chk(endAddr == b + (w ? 32'd28 : 32'd14), "R11", "end address", endAddr, b + (w ? 32'd28 : 32'd14));
    chk(xferCount == 7, "R2", "transfer count", 32'(xferCount), 7);
    chk(xferBad == 0, "R2", "transfer address order", 32'(xferBad), 0);
    @(negedge clk);
    chk(!done, "R11", "done one cycle", 32'(done), 0);
    if (ld) ;
  endtask

  function automatic logic [31:0] expSlot(int idx, bit p, bit w);
    logic [31:0] hi = w ? 32'hFFFF0000 : 32'h0;
    logic [31:0] ipL = 32'(ipSelIn) * 16 + ipOffIn;
    logic [31:0] dpL = 32'(dpSelIn) * 16 + dpOffIn;
    logic [31:0] st = 32'((statIn & 16'hC7FF) | (16'(topIn) << 11));
    case (idx)
      0: return hi | 32'(ctlIn);
      1: return hi | st;
      2: return hi | 32'(tagIn);
      3: return p ? (w ? ipOffIn : (ipOffIn & 32'hFFFF)) : (hi | (ipL & 32'hFFFF));
      4: return p ? (w ? ((32'(opcIn) << 16) | 32'(ipSelIn)) : 32'(ipSelIn))
                  : (w ? (((ipL & 32'hFFFF0000) >> 4) | 32'(opcIn))
                       : (((ipL & 32'h000F0000) >> 4) | 32'(opcIn)));
      5: return p ? (w ? dpOffIn : (dpOffIn & 32'hFFFF)) : (hi | (dpL & 32'hFFFF));
      default: return p ? (w ? (32'hFFFF0000 | 32'(dpSelIn)) : 32'(dpSelIn))
                        : (w ? ((dpL & 32'hFFFF0000) >> 4) : ((dpL & 32'h000F0000) >> 4));
    endcase
  endfunction

  // R3..R6, R13: store one image and compare every slot
  task automatic t_store(bit p, bit w, logic [31:0] b, int l);
    logic [15:0] keepCtl = ctlOut;
    logic [31:0] keepIp = ipOffOut;
    logic [10:0] keepOpc = opcOut;
    lat = l;
    fillMem(8'hEE);
    launch(1'b0, p, w, b);
    chk(memWrite || !memReq, "R2", "write direction", 32'(memWrite), 1);
    waitDone(1'b0, w, b);
    for (int i = 0; i < 7; i++) begin
      logic [31:0] a = rdMem(8'(b + 32'(i * (w ? 4 : 2))), w);
      string r = (i < 3) ? "R3" : (p ? "R6" : (w ? "R5" : "R4"));
      chk(a == expSlot(i, p, w), r, $sformatf("store slot %0d", i), a, expSlot(i, p, w));
    end
    chk(mem[8'(b + (w ? 32'd28 : 32'd14))] == 8'hEE, "R2", "no write past image",
        32'(mem[8'(b + (w ? 32'd28 : 32'd14))]), 32'hEE);
    chk(ctlOut == keepCtl && ipOffOut == keepIp && opcOut == keepOpc, "R13",
        "outputs unchanged by store", {ctlOut, 5'b0, opcOut}, {keepCtl, 5'b0, keepOpc});
  endtask

  // R7..R10: load an image and compare every restored field
  task automatic t_load(bit p, bit w, logic [31:0] b, int l,
                        logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3,
                        logic [31:0] w4, logic [31:0] w5, logic [31:0] w6);
    logic [15:0] eCtl, eStat, eIpSel, eDpSel;
    logic [31:0] eIp, eDp;
    logic [10:0] eOpc;
    bit pend;
    string r = p ? "R8" : "R7";
    int s = w ? 4 : 2;
    lat = l;
    fillMem(8'hA5);
    putWord(8'(b), w0, w); putWord(8'(b + s), w1, w); putWord(8'(b + 2*s), w2, w);
    putWord(8'(b + 3*s), w3, w); putWord(8'(b + 4*s), w4, w);
    putWord(8'(b + 5*s), w5, w); putWord(8'(b + 6*s), w6, w);
    launch(1'b1, p, w, b);
    chk(!memWrite, "R2", "read direction", 32'(memWrite), 0);
    waitDone(1'b1, w, b);
    eCtl  = (w0[15:0] & ~16'hE0C0) | 16'h0040;
    pend  = ((w1[5:0] & ~eCtl[5:0]) != 6'b0);
    eStat = pend ? (w1[15:0] | 16'h8080) : (w1[15:0] & ~16'h8080);
    if (!p) begin
      eIp = w ? (((w4 & 32'h0FFFF000) << 4) | (w3 & 32'hFFFF)) : (((w4 & 32'hF000) << 4) | (w3 & 32'hFFFF));
      eDp = w ? (((w6 & 32'h0FFFF000) << 4) | (w5 & 32'hFFFF)) : (((w6 & 32'hF000) << 4) | (w5 & 32'hFFFF));
      eIpSel = 0; eDpSel = 0; eOpc = w4[10:0];
    end else begin
      eIp = w ? w3 : (w3 & 32'hFFFF);
      eDp = w ? w5 : (w5 & 32'hFFFF);
      eIpSel = w4[15:0]; eDpSel = w6[15:0];
      eOpc = w ? w4[26:16] : opcIn;
    end
    chk(ctlOut == eCtl, "R9", "control word", 32'(ctlOut), 32'(eCtl));
    chk(topOut == w1[13:11], "R9", "stack top", 32'(topOut), 32'(w1[13:11]));
    chk(tagOut == w2[15:0], "R9", "tag word", 32'(tagOut), 32'(w2[15:0]));
    chk(statOut == eStat, "R10", "status word flags", 32'(statOut), 32'(eStat));
    chk(ipOffOut == eIp, r, "ip offset", ipOffOut, eIp);
    chk(ipSelOut == eIpSel, r, "ip selector", 32'(ipSelOut), 32'(eIpSel));
    chk(opcOut == eOpc, r, "opcode", 32'(opcOut), 32'(eOpc));
    chk(dpOffOut == eDp, r, "operand offset", dpOffOut, eDp);
    chk(dpSelOut == eDpSel, r, "operand selector", 32'(dpSelOut), 32'(eDpSel));
  endtask

  // R12: second start while busy must not disturb the running store
  task automatic t_busy_start();
    lat = 2;
    fillMem(8'hEE);
    launch(1'b0, 1'b0, 1'b1, 32'h40);
    repeat (4) @(negedge clk);
    op32 = 1'b0; protMode = 1'b1; baseAddr = 32'h90; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op32 = 1'b1; protMode = 1'b0; baseAddr = 32'h40;
    waitDone(1'b0, 1'b1, 32'h40);
    for (int i = 0; i < 7; i++) begin
      logic [31:0] a = rdMem(8'(32'h40 + 32'(i * 4)), 1'b1);
      chk(a == expSlot(i, 1'b0, 1'b1), "R12", $sformatf("slot %0d after busy start", i), a, expSlot(i, 1'b0, 1'b1));
    end
    repeat (3) begin
      @(negedge clk);
      chk(!memReq && !busy, "R12", "no extra transfer", 32'(memReq), 0);
    end
    chk(mem[8'h90] == 8'hEE, "R12", "ignored base untouched", 32'(mem[8'h90]), 32'hEE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReq, "R1", "control idle in reset", {29'b0, busy, done, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReq, "R1", "idle after reset", {29'b0, busy, done, memReq}, 0);
    chk(ctlOut == 0 && statOut == 0 && ipOffOut == 0 && dpSelOut == 0 && topOut == 0,
        "R1", "restored fields zero", {ctlOut, statOut}, 0);

    ctlIn = 16'h037F; statIn = 16'h3821; tagIn = 16'h5A5A; topIn = 3'd2;
    ipSelIn = 16'h1234; ipOffIn = 32'h0000F678; opcIn = 11'h5A3;
    dpSelIn = 16'hF00D; dpOffIn = 32'h0000BEEF;
    t_store(1'b0, 1'b0, 32'h10, 0);
    t_store(1'b0, 1'b1, 32'h20, 3);
    ipOffIn = 32'hCAFE1234; dpOffIn = 32'h89ABCDEF; topIn = 3'd5;
    t_store(1'b1, 1'b0, 32'h30, 1);
    t_store(1'b1, 1'b1, 32'h44, 2);

    // real narrow, unmasked exception pending
    t_load(1'b0, 1'b0, 32'h10, 1, 32'hFFFF_E3C2, 32'h0000_2805, 32'h0000_A55A, 32'h0000_1357,
           32'h0000_B6F1, 32'h0000_2468, 32'h0000_7000);
    // real wide, everything masked
    t_load(1'b0, 1'b1, 32'h20, 0, 32'h0000_037F, 32'h0000_B8BF, 32'h0000_0F0F, 32'hFFFF_4321,
           32'h0ABC_D7FF, 32'hFFFF_8765, 32'h0123_4000);
    // protected narrow, opcode kept from opcIn
    opcIn = 11'h2C9;
    t_load(1'b1, 1'b0, 32'h60, 2, 32'h0000_0372, 32'h0000_0004, 32'h0000_1111, 32'h0000_ABCD,
           32'h0000_0808, 32'h0000_5555, 32'h0000_0F0F);
    // protected wide
    t_load(1'b1, 1'b1, 32'h80, 1, 32'h0000_FFFF, 32'h0000_3801, 32'h0000_C3C3, 32'hDEAD_BEEF,
           32'h0567_0010, 32'h1357_9BDF, 32'hFFFF_0018);
    // R13: store after load keeps restored fields
    t_store(1'b1, 1'b1, 32'h08, 0);
    t_busy_start();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule